// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block decides whether a pending interrupt is strong enough to interrupt the current code. It holds two writable registers. One is the current priority level. The other is a field of software interrupt requests. It also watches a group of external interrupt lines. When the `eval` strobe is high, it works out the highest pending level and compares that level with the current priority level.

The software requests cover levels 1 to 15. The external lines cover levels 16 and up, so any active external line outranks every software request. When the pending level is strictly above the current level, the block does three things on the next edge. It records a summary vector holding every pending request bit at its own position. It records the winning level number. It raises a one-cycle trap request. A losing evaluation leaves both recorded values untouched.

The strobe is meant to be raised after an exception return or after a change of priority level. Trap vectoring, register shadowing and asynchronous traps belong to other logic.

Top module: `irq_level_eval`

## Requirements
- R1: After reset, `trap_req`, `int_summary`, `int_id`, `cur_ipl` and `sw_req` are all zero.
- R2: A write with `ipl_we` keeps only bits 4:0 of `ipl_wdata`. The new value appears on `cur_ipl` one cycle later.
- R3: A write with `swr_we` keeps only bits 18:4 of `swr_wdata` (mask 0x0007FFF0). Every other bit of `sw_req` reads as zero.
- R4: When no external line is active, the highest set software bit k (4 to 18) gives level k-3. With no request at all, the level is 0.
- R5: External line j (0 to 11) gives level 16+j, and the highest active line wins. Any active line overrides the software result.
- R6: An evaluation is taken only when the level is nonzero and strictly greater than `cur_ipl`. An equal level is not taken.
- R7: A taken evaluation has three effects one cycle after the `eval` edge. `trap_req` is high for exactly that cycle. `int_id` holds the level. `int_summary` holds software bits 18:4 together with external line j at bit 19+j.
- R8: A cycle without `eval`, or an evaluation that is not taken, leaves `int_summary` and `int_id` unchanged and gives no trap.
- R9: When `eval` coincides with a register write, the evaluation uses the register values held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ipl_we | input | 1 | Write strobe for the priority level register |
| ipl_wdata | input | 32 | Write data for the priority level register |
| swr_we | input | 1 | Write strobe for the software request register |
| swr_wdata | input | 32 | Write data for the software request register |
| ext_irq | input | 12 | External interrupt lines (synchronous) |
| eval | input | 1 | Evaluate strobe |
| cur_ipl | output | 5 | Current priority level |
| sw_req | output | 32 | Software request register |
| trap_req | output | 1 | One-cycle interrupt trap request |
| int_summary | output | 32 | Captured pending-request summary |
| int_id | output | 5 | Captured winning level |

## Verification
A register write and an evaluation can fall on the same clock edge. Either the priority level or the software requests may be rewritten in the very cycle the strobe is sampled. The bench drives such collisions in directed steps and in random steps. One directed step raises the level to 31 while evaluating a pending software request, and the request must still win. The bench's reference model always evaluates with the register values from before the edge and updates its registers afterwards. A design that lets the new write leak into the comparison therefore disagrees on `trap_req`, `int_id` or `int_summary`.

// File: rtl/irq_lvl_pkg.sv
`timescale 1ns/1ps
package irq_lvl_pkg;

  // Contiguous field mask of n ones starting at bit lo.
  function automatic logic [63:0] field_mask(input int lo, input int n);
    logic [63:0] m;
    m = '0;
    for (int b = 0; b < 64; b++) begin
      if (b >= lo && b < lo + n) m[b] = 1'b1;
    end
    return m;
  endfunction

  // Pending level wins only when nonzero and strictly above current level.
  function automatic logic level_beats(input logic [7:0] lvl, input logic [7:0] cur);
    return (lvl != 8'd0) && (lvl > cur);
  endfunction

endpackage

// File: rtl/irq_lvl_regs.sv
`timescale 1ns/1ps
module irq_lvl_regs
  import irq_lvl_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LW    = 5,
  parameter int SW_LO = 4,
  parameter int SW_N  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ipl_we,
  input  logic [DW-1:0] ipl_wdata,
  input  logic          swr_we,
  input  logic [DW-1:0] swr_wdata,
  output logic [LW-1:0] ipl_q,
  output logic [DW-1:0] sw_q
);
  localparam logic [DW-1:0] SW_MASK  = DW'(field_mask(SW_LO, SW_N));
  localparam logic [DW-1:0] IPL_MASK = DW'(field_mask(0, LW));

  logic [DW-1:0] ipl_masked;
  assign ipl_masked = ipl_wdata & IPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipl_q <= '0;
      sw_q  <= '0;
    end else begin
      if (ipl_we) ipl_q <= ipl_masked[LW-1:0];
      if (swr_we) sw_q  <= swr_wdata & SW_MASK;
    end
  end
endmodule

// File: rtl/irq_lvl_scan.sv
`timescale 1ns/1ps
module irq_lvl_scan #(
  parameter int N    = 15,
  parameter int LW   = 5,
  parameter int BASE = 1
) (
  input  logic [N-1:0]  req,
  output logic [LW-1:0] lvl,
  output logic          any
);
  logic [LW-1:0] cand [N];

  for (genvar i = 0; i < N; i++) begin : g_cand
    assign cand[i] = req[i] ? LW'(BASE + i) : '0;
  end

  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] > lvl) lvl = cand[i];
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_lvl_capture.sv
`timescale 1ns/1ps
module irq_lvl_capture
  import irq_lvl_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  logic [LW-1:0] lvl,
  input  logic [LW-1:0] cur_ipl,
  input  logic [DW-1:0] summary_d,
  output logic          beat,
  output logic          trap_q,
  output logic [DW-1:0] sum_q,
  output logic [LW-1:0] id_q
);
  logic take;

  assign beat = level_beats(8'(lvl), 8'(cur_ipl));
  assign take = eval & beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      sum_q  <= '0;
      id_q   <= '0;
    end else begin
      trap_q <= take;
      if (take) begin
        sum_q <= summary_d;
        id_q  <= lvl;
      end
    end
  end
endmodule

// File: rtl/irq_level_eval.sv
`timescale 1ns/1ps
module irq_level_eval #(
  parameter int DW    = 32,
  parameter int LW    = 5,
  parameter int SW_LO = 4,
  parameter int SW_N  = 15,
  parameter int EXT_N = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ipl_we,
  input  logic [DW-1:0]    ipl_wdata,
  input  logic             swr_we,
  input  logic [DW-1:0]    swr_wdata,
  input  logic [EXT_N-1:0] ext_irq,
  input  logic             eval,
  output logic [LW-1:0]    cur_ipl,
  output logic [DW-1:0]    sw_req,
  output logic             trap_req,
  output logic [DW-1:0]    int_summary,
  output logic [LW-1:0]    int_id
);
  localparam int EXT_LO   = SW_LO + SW_N;
  localparam int EXT_BASE = SW_N + 1;

  // Named internal events, observed by the bound checker.
  logic [LW-1:0] sw_lvl_w, ext_lvl_w, lvl_w;
  logic          sw_any_w, ext_any_w, beat_w, take_w;
  logic [DW-1:0] summary_w;

  irq_lvl_regs #(.DW(DW), .LW(LW), .SW_LO(SW_LO), .SW_N(SW_N)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ipl_we(ipl_we), .ipl_wdata(ipl_wdata),
    .swr_we(swr_we), .swr_wdata(swr_wdata),
    .ipl_q(cur_ipl), .sw_q(sw_req)
  );

  irq_lvl_scan #(.N(SW_N), .LW(LW), .BASE(1)) u_sw_scan (
    .req(sw_req[SW_LO +: SW_N]), .lvl(sw_lvl_w), .any(sw_any_w)
  );

  irq_lvl_scan #(.N(EXT_N), .LW(LW), .BASE(EXT_BASE)) u_ext_scan (
    .req(ext_irq), .lvl(ext_lvl_w), .any(ext_any_w)
  );

  assign lvl_w     = ext_any_w ? ext_lvl_w : (sw_any_w ? sw_lvl_w : '0);
  assign summary_w = sw_req | (DW'(ext_irq) << EXT_LO);
  assign take_w    = eval & beat_w;

  irq_lvl_capture #(.DW(DW), .LW(LW)) u_cap (
    .clk(clk), .rst_n(rst_n), .eval(eval),
    .lvl(lvl_w), .cur_ipl(cur_ipl), .summary_d(summary_w),
    .beat(beat_w), .trap_q(trap_req), .sum_q(int_summary), .id_q(int_id)
  );
endmodule

// File: rtl/irq_level_eval_chk.sv
`timescale 1ns/1ps
module irq_level_eval_chk
  import irq_lvl_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LW    = 5,
  parameter int SW_LO = 4,
  parameter int SW_N  = 15,
  parameter int EXT_N = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ipl_we,
  input logic [DW-1:0]    ipl_wdata,
  input logic             swr_we,
  input logic [DW-1:0]    swr_wdata,
  input logic [EXT_N-1:0] ext_irq,
  input logic [LW-1:0]    cur_ipl,
  input logic [DW-1:0]    sw_req,
  input logic             trap_req,
  input logic [DW-1:0]    int_summary,
  input logic [LW-1:0]    int_id,
  input logic [LW-1:0]    lvl_w,
  input logic [DW-1:0]    summary_w,
  input logic             take_w
);
  localparam logic [DW-1:0] SWM = DW'(field_mask(SW_LO, SW_N));
  localparam int EXT_BASE = SW_N + 1;

  p_ipl_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_we |=> cur_ipl == $past(ipl_wdata[LW-1:0]));

  p_sw_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swr_we |=> sw_req == ($past(swr_wdata) & SWM));

  p_ext_over_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_irq) |-> (32'(lvl_w) >= EXT_BASE));

  p_strict_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (int_id != '0) && (int_id > $past(cur_ipl)));

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> trap_req && int_id == $past(lvl_w) && int_summary == $past(summary_w));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_w |=> !trap_req && $stable(int_summary) && $stable(int_id));
endmodule

bind irq_level_eval irq_level_eval_chk #(
  .DW(DW), .LW(LW), .SW_LO(SW_LO), .SW_N(SW_N), .EXT_N(EXT_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ipl_we(ipl_we), .ipl_wdata(ipl_wdata),
  .swr_we(swr_we), .swr_wdata(swr_wdata), .ext_irq(ext_irq),
  .cur_ipl(cur_ipl), .sw_req(sw_req), .trap_req(trap_req),
  .int_summary(int_summary), .int_id(int_id),
  .lvl_w(lvl_w), .summary_w(summary_w), .take_w(take_w)
);

// File: tb/irq_level_eval_tb.sv
`timescale 1ns/1ps
module irq_level_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ipl_we = 1'b0;
  logic [31:0] ipl_wdata = '0;
  logic        swr_we = 1'b0;
  logic [31:0] swr_wdata = '0;
  logic [11:0] ext_irq = '0;
  logic        eval = 1'b0;
  logic [4:0]  cur_ipl;
  logic [31:0] sw_req;
  logic        trap_req;
  logic [31:0] int_summary;
  logic [4:0]  int_id;

  int errors = 0;
  int checks = 0;

  // Reference state
  logic [4:0]  m_ipl = '0;
  logic [31:0] m_sw  = '0;
  logic [31:0] m_sum = '0;
  logic [4:0]  m_id  = '0;

  always #5 clk = ~clk;

  irq_level_eval u_dut (
    .clk(clk), .rst_n(rst_n), .ipl_we(ipl_we), .ipl_wdata(ipl_wdata),
    .swr_we(swr_we), .swr_wdata(swr_wdata), .ext_irq(ext_irq), .eval(eval),
    .cur_ipl(cur_ipl), .sw_req(sw_req), .trap_req(trap_req),
    .int_summary(int_summary), .int_id(int_id)
  );

  function automatic int exp_level(input logic [31:0] sw, input logic [11:0] ext);
    for (int j = 11; j >= 0; j--) if (ext[j]) return 16 + j;
    for (int k = 18; k >= 4; k--) if (sw[k]) return k - 3;
    return 0;
  endfunction

  function automatic logic [31:0] exp_summary(input logic [31:0] sw, input logic [11:0] ext);
    logic [31:0] s;
    s = sw & 32'h0007_FFF0;
    for (int j = 0; j < 12; j++) s[19 + j] = ext[j];
    return s;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive after a falling edge, sample at the next falling edge.
  task automatic step(input string tag, input logic iwe, input logic [31:0] id,
                      input logic swe, input logic [31:0] sd,
                      input logic ev, input logic [11:0] ext);
    int  lvl;
    logic take;
    ipl_we = iwe; ipl_wdata = id; swr_we = swe; swr_wdata = sd;
    eval = ev; ext_irq = ext;
    // R9: expectation uses the register values held before this edge
    lvl  = exp_level(m_sw, ext);
    take = ev && (lvl != 0) && (lvl > int'(m_ipl));
    if (take) begin
      m_sum = exp_summary(m_sw, ext);
      m_id  = 5'(lvl);
    end
    if (iwe) m_ipl = id[4:0];
    if (swe) m_sw  = sd & 32'h0007_FFF0;
    @(negedge clk);
    ipl_we = 1'b0; swr_we = 1'b0; eval = 1'b0;
    chk(tag, "trap_req", 32'(trap_req), 32'(take));
    chk(tag, "int_summary", int_summary, m_sum);
    chk(tag, "int_id", 32'(int_id), 32'(m_id));
    chk(tag, "cur_ipl", 32'(cur_ipl), 32'(m_ipl));
    chk(tag, "sw_req", sw_req, m_sw);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "trap_req", 32'(trap_req), 0);
    chk("R1", "int_summary", int_summary, 0);
    chk("R1", "int_id", 32'(int_id), 0);
    chk("R1", "cur_ipl", 32'(cur_ipl), 0);
    chk("R1", "sw_req", sw_req, 0);

    // R2 only low five bits kept
    step("R2", 1, 32'hFFFF_FFE3, 0, 0, 0, 0);
    // R3 only bits 18:4 kept
    step("R3", 0, 0, 1, 32'hFFFF_FFFF, 0, 0);
    // R6 nothing pending: level 0 never taken even at IPL 0
    step("R6", 1, 0, 1, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    // R4 lowest software bit gives level 1
    step("R4", 0, 0, 1, 32'h0000_0010, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 0, 0);          // pulse ends after one cycle
    // R4 highest software bit wins: bits 18 and 4 -> 15
    step("R4", 0, 0, 1, 32'h0004_0010, 1, 0);
    step("R4", 0, 0, 0, 0, 1, 0);
    // R6 equal level not taken, one below taken
    step("R6", 1, 32'd15, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    step("R6", 1, 32'd14, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    // R5 external overrides software; highest line wins
    step("R5", 1, 32'd0, 1, 32'h0007_FFF0, 1, 12'h001);
    step("R5", 0, 0, 0, 0, 1, 12'h801);
    step("R7", 0, 0, 0, 0, 1, 12'h0A5);
    // R8 losing evaluation and no-strobe cycles keep captured state
    step("R8", 1, 32'd31, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 12'hFFF);
    step("R8", 1, 32'd0, 0, 0, 0, 12'h800);
    // R9 write in same cycle as eval: old IPL 0 used, so taken
    step("R9", 1, 32'd31, 0, 0, 1, 12'h000);
    step("R9", 0, 0, 0, 0, 1, 12'h000);
    // R9 software write with eval: old requests used
    step("R9", 1, 32'd0, 1, 0, 0, 0);
    step("R9", 0, 0, 1, 32'h0000_0100, 1, 0);
    step("R9", 0, 0, 0, 0, 1, 0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] e;
      e = 12'($urandom) & 12'($urandom) & 12'($urandom);
      if ($urandom % 3 == 0) e = '0;
      step("R9", ($urandom % 4) == 0, $urandom, ($urandom % 4) == 0,
           $urandom & $urandom, ($urandom % 2) == 0, e);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule